// File: doc/BRIEF.md
# Four-Slot Edge Timestamp Unit

This block records the time at which edges arrive on a single asynchronous input. A free-running counter provides the time base. Each qualified edge writes the counter value into one of four stamp registers, which are chosen in strict rotation. Each slot has its own edge sense. Each slot can also clear the counter once its stamp has been stored. Clearing gives delta timing, such as pulse widths and periods. Leaving the counter running gives absolute timing.

Before edge qualification, the input can be thinned by an event divider. The divider takes an even ratio. A debug halt input can freeze the time base in one of three ways:
- at once,
- once the count reaches zero,
- never.

All configuration arrives as static control inputs. Every qualified event produces a one-cycle strobe on the output bit of the slot it served.

Top module: `edge_stamp_unit`

## Requirements
- R1: After reset, all four stamps are 0, no strobe is active, and the first qualified event is served by slot 0.
- R2: `cfg_prediv` = 0 passes every synchronized edge through. A value N > 0 makes the qualified-event stream a square wave at 1/(2N) of the input's rising-edge rate. The wave toggles on every Nth rising input edge and starts low after reset.
- R3: Bit i of `cfg_edge_fall` selects the edge for slot i: 0 qualifies a rising edge and 1 qualifies a falling edge of the divided stream.
- R4: Qualified events are served by slots 0, 1, 2, 3, 0 and so on. Each event raises exactly bit k of `evt_strobe` for one cycle, where k is the slot that served it.
- R5: When bit k of `cfg_clr_after` is set, an event on slot k stores the counter value from before the clear. The counter is 0 in the next cycle, so an interval of D cycles stamps D-1.
- R6: When no clear bit is set, stamps are absolute, and two events D cycles apart differ by D.
- R7: While `cfg_load_en` is 0, events leave all stamps unchanged. They still raise strobes and advance the slot rotation.
- R8: When `cfg_halt_mode` = 0, the counter holds its value in every cycle in which `halt_req` is 1.
- R9: When `cfg_halt_mode` = 1, a halt request does not stop a nonzero counter. Once the counter is 0, it stays at 0 while `halt_req` is 1.
- R10: When `cfg_halt_mode` is 2 or 3, `halt_req` has no effect on the counter.
- R11: In bypass, a strobe appears on the third rising clock edge after the input changes. With any nonzero divide ratio, it appears on the fourth.
- R12: A change of `cfg_prediv` restarts the divider's edge count, so the first toggle at the new ratio N needs N fresh rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prediv | input | 5 | Divide selector: 0 bypass, N gives 1/(2N) |
| cfg_edge_fall | input | 4 | Per-slot edge sense, 1 means falling |
| cfg_clr_after | input | 4 | Per-slot counter clear after stamping |
| cfg_load_en | input | 1 | Global enable for stamp register writes |
| cfg_halt_mode | input | 2 | Halt behaviour: 0 at once, 1 at zero, 2/3 ignore |
| sig_in | input | 1 | Asynchronous signal being timed |
| halt_req | input | 1 | Debug halt request |
| stamp_0 | output | 32 | Stamp of slot 0 |
| stamp_1 | output | 32 | Stamp of slot 1 |
| stamp_2 | output | 32 | Stamp of slot 2 |
| stamp_3 | output | 32 | Stamp of slot 3 |
| evt_strobe | output | 4 | One-cycle pulse, bit k for slot k |

## Verification
The stamping path is driven with square waves of several duty cycles and divide ratios.
- A symmetric wave with all slots on rising edges checks the period.
- An asymmetric wave with all slots on falling edges checks the same interval seen through the other edge sense.
- An alternating slot polarity mask separates high time from low time, so a swapped polarity bit or slot order changes the stamped values.

Absolute sequences with a clear on only one slot show whether the stored value is taken before or after the clear. Halt windows placed between two edges distinguish freezing, running on to zero, and ignoring the request.

// File: rtl/est_pkg.sv
package est_pkg;

  localparam int unsigned EST_SLOTS = 4;
  localparam int unsigned EST_PTR_W = 2;

  typedef enum logic [1:0] {
    HALT_NOW     = 2'd0,
    HALT_AT_ZERO = 2'd1,
    HALT_IGN_A   = 2'd2,
    HALT_IGN_B   = 2'd3
  } halt_mode_e;

  // Decide whether the time base advances this cycle.
  function automatic logic count_enable(input halt_mode_e mode,
                                        input logic req,
                                        input logic at_zero);
    logic run;
    case (mode)
      HALT_NOW:     run = !req;
      HALT_AT_ZERO: run = !(req && at_zero);
      default:      run = 1'b1;
    endcase
    return run;
  endfunction

  // Rotating slot pointer, modulo the slot count.
  function automatic logic [EST_PTR_W-1:0] slot_after(input logic [EST_PTR_W-1:0] p);
    return p + EST_PTR_W'(1);
  endfunction

  // One-hot code of a slot index.
  function automatic logic [EST_SLOTS-1:0] slot_onehot(input logic [EST_PTR_W-1:0] p);
    logic [EST_SLOTS-1:0] v;
    v = '0;
    v[p] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/est_sync.sv
module est_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/est_prescaler.sv
module est_prescaler #(
  parameter int unsigned PRE_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl,
  input  logic [PRE_W-1:0] ratio,
  output logic             div_out,
  output logic             ratio_changed
);
  logic             lvl_q;
  logic             tgl;
  logic [PRE_W-1:0] edge_cnt;
  logic [PRE_W-1:0] ratio_q;
  logic             lvl_rise;
  logic             bypass;

  function automatic logic at_terminal(input logic [PRE_W-1:0] c,
                                       input logic [PRE_W-1:0] n);
    return c == (n - PRE_W'(1));
  endfunction

  assign lvl_rise      = lvl && !lvl_q;
  assign bypass        = (ratio == '0);
  assign ratio_changed = (ratio != ratio_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q    <= 1'b0;
      tgl      <= 1'b0;
      edge_cnt <= '0;
      ratio_q  <= '0;
    end else begin
      lvl_q   <= lvl;
      ratio_q <= ratio;
      if (ratio_changed) begin
        edge_cnt <= '0;
      end else if (lvl_rise && !bypass) begin
        if (at_terminal(edge_cnt, ratio)) begin
          edge_cnt <= '0;
          tgl      <= !tgl;
        end else begin
          edge_cnt <= edge_cnt + PRE_W'(1);
        end
      end
    end
  end

  assign div_out = bypass ? lvl : tgl;
endmodule

// File: rtl/est_timebase.sv
module est_timebase
  import est_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             halt_req,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             advancing
);
  halt_mode_e mode_e;

  assign mode_e    = halt_mode_e'(mode);
  assign advancing = count_enable(mode_e, halt_req, count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         count <= '0;
    else if (clr)       count <= '0;
    else if (advancing) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/est_capture_bank.sv
module est_capture_bank
  import est_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           evt,
  input  logic                           load_en,
  input  logic [CNT_W-1:0]               time_now,
  output logic [EST_PTR_W-1:0]           ptr,
  output logic [EST_SLOTS*CNT_W-1:0]     stamps_flat,
  output logic [EST_SLOTS-1:0]           strobe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      strobe <= '0;
    end else begin
      strobe <= evt ? slot_onehot(ptr) : '0;
      if (evt) ptr <= slot_after(ptr);
    end
  end

  for (genvar i = 0; i < EST_SLOTS; i++) begin : g_slot
    logic [CNT_W-1:0] stamp_r;
    logic             wr_en;

    assign wr_en = evt && load_en && (ptr == EST_PTR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     stamp_r <= '0;
      else if (wr_en) stamp_r <= time_now;
    end

    assign stamps_flat[i*CNT_W +: CNT_W] = stamp_r;
  end
endmodule

// File: rtl/edge_stamp_unit.sv
module edge_stamp_unit
  import est_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned PRE_W       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] cfg_prediv,
  input  logic [3:0]       cfg_edge_fall,
  input  logic [3:0]       cfg_clr_after,
  input  logic             cfg_load_en,
  input  logic [1:0]       cfg_halt_mode,
  input  logic             sig_in,
  input  logic             halt_req,
  output logic [CNT_W-1:0] stamp_0,
  output logic [CNT_W-1:0] stamp_1,
  output logic [CNT_W-1:0] stamp_2,
  output logic [CNT_W-1:0] stamp_3,
  output logic [3:0]       evt_strobe
);
  // Named internal events, also used by the bound checker.
  logic                       sig_sync;
  logic                       div_sig;
  logic                       div_q;
  logic                       div_rise;
  logic                       div_fall;
  logic                       ratio_changed;
  logic                       qual_evt;
  logic                       clr_now;
  logic                       tb_advancing;
  logic [EST_PTR_W-1:0]       slot_ptr;
  logic [CNT_W-1:0]           tick_cnt;
  logic [EST_SLOTS*CNT_W-1:0] stamps_flat;

  est_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(sig_in),
    .q_sync (sig_sync)
  );

  est_prescaler #(.PRE_W(PRE_W)) u_prescaler (
    .clk          (clk),
    .rst_n        (rst_n),
    .lvl          (sig_sync),
    .ratio        (cfg_prediv),
    .div_out      (div_sig),
    .ratio_changed(ratio_changed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= 1'b0;
    else        div_q <= div_sig;
  end

  assign div_rise = div_sig && !div_q;
  assign div_fall = !div_sig && div_q;
  assign qual_evt = cfg_edge_fall[slot_ptr] ? div_fall : div_rise;
  assign clr_now  = qual_evt && cfg_clr_after[slot_ptr];

  est_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (cfg_halt_mode),
    .halt_req (halt_req),
    .clr      (clr_now),
    .count    (tick_cnt),
    .advancing(tb_advancing)
  );

  est_capture_bank #(.CNT_W(CNT_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (qual_evt),
    .load_en    (cfg_load_en),
    .time_now   (tick_cnt),
    .ptr        (slot_ptr),
    .stamps_flat(stamps_flat),
    .strobe     (evt_strobe)
  );

  assign stamp_0 = stamps_flat[0*CNT_W +: CNT_W];
  assign stamp_1 = stamps_flat[1*CNT_W +: CNT_W];
  assign stamp_2 = stamps_flat[2*CNT_W +: CNT_W];
  assign stamp_3 = stamps_flat[3*CNT_W +: CNT_W];
endmodule

// File: rtl/edge_stamp_unit_chk.sv
module edge_stamp_unit_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_load_en,
  input logic [1:0]       cfg_halt_mode,
  input logic             halt_req,
  input logic             qual_evt,
  input logic             clr_now,
  input logic [1:0]       slot_ptr,
  input logic [CNT_W-1:0] tick_cnt,
  input logic [CNT_W-1:0] stamp_0,
  input logic [CNT_W-1:0] stamp_1,
  input logic [CNT_W-1:0] stamp_2,
  input logic [CNT_W-1:0] stamp_3,
  input logic [3:0]       evt_strobe
);
  logic [CNT_W-1:0] st_sel;
  logic [1:0]       ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= slot_ptr;
  end

  always_comb begin
    case (ptr_q)
      2'd0:    st_sel = stamp_0;
      2'd1:    st_sel = stamp_1;
      2'd2:    st_sel = stamp_2;
      default: st_sel = stamp_3;
    endcase
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(evt_strobe)); // R4
  AST_STROBE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    qual_evt |=> evt_strobe == (4'b0001 << ptr_q)); // R4
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    qual_evt |=> slot_ptr == ptr_q + 2'd1); // R4
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !qual_evt |=> $stable(slot_ptr)); // R4
  AST_STAMP_PRECLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_evt && cfg_load_en) |=> st_sel == $past(tick_cnt)); // R5
  AST_CLEAR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    clr_now |=> tick_cnt == '0); // R5
  AST_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load_en |=> ($stable(stamp_0) && $stable(stamp_1) && $stable(stamp_2) && $stable(stamp_3))); // R7
  AST_HALT_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_halt_mode == 2'd0 && halt_req && !clr_now) |=> $stable(tick_cnt)); // R8
  AST_HALT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_halt_mode == 2'd1 && halt_req && tick_cnt == '0) |=> tick_cnt == '0); // R9
  AST_HALT_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_halt_mode == 2'd1 && tick_cnt != '0 && !clr_now) |=> tick_cnt == $past(tick_cnt) + 1'b1); // R9
  AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_halt_mode[1] && !clr_now) |=> tick_cnt == $past(tick_cnt) + 1'b1); // R10
endmodule

bind edge_stamp_unit edge_stamp_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_load_en  (cfg_load_en),
  .cfg_halt_mode(cfg_halt_mode),
  .halt_req     (halt_req),
  .qual_evt     (qual_evt),
  .clr_now      (clr_now),
  .slot_ptr     (slot_ptr),
  .tick_cnt     (tick_cnt),
  .stamp_0      (stamp_0),
  .stamp_1      (stamp_1),
  .stamp_2      (stamp_2),
  .stamp_3      (stamp_3),
  .evt_strobe   (evt_strobe)
);

// File: tb/edge_stamp_unit_bench.sv
module edge_stamp_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_prediv = '0;
  logic [3:0]  cfg_edge_fall = '0;
  logic [3:0]  cfg_clr_after = '0;
  logic        cfg_load_en = 1'b0;
  logic [1:0]  cfg_halt_mode = '0;
  logic        sig_in = 1'b0;
  logic        halt_req = 1'b0;
  logic [31:0] stamp_0, stamp_1, stamp_2, stamp_3;
  logic [3:0]  evt_strobe;

  int n_checks = 0;
  int n_err = 0;
  int mon_checks = 0;
  int mon_err = 0;
  logic [1:0] exp_slot;
  logic [3:0] strobe_seen;

  always #4 clk = !clk;

  edge_stamp_unit u_edge_stamp_unit (
    .clk(clk), .rst_n(rst_n), .cfg_prediv(cfg_prediv), .cfg_edge_fall(cfg_edge_fall),
    .cfg_clr_after(cfg_clr_after), .cfg_load_en(cfg_load_en), .cfg_halt_mode(cfg_halt_mode),
    .sig_in(sig_in), .halt_req(halt_req), .stamp_0(stamp_0), .stamp_1(stamp_1),
    .stamp_2(stamp_2), .stamp_3(stamp_3), .evt_strobe(evt_strobe)
  );

  // R4 rotation monitor: every strobe must be one-hot on the next expected slot.
  always @(negedge clk) begin
    if (!rst_n) begin
      exp_slot    <= 2'd0;
      strobe_seen <= 4'b0000;
    end else if (evt_strobe != 4'b0000) begin
      mon_checks <= mon_checks + 1;
      if (evt_strobe !== (4'b0001 << exp_slot)) begin
        mon_err <= mon_err + 1;
        $display("FAIL R4 strobe actual=%b expected=%b", evt_strobe, 4'b0001 << exp_slot);
      end
      exp_slot    <= exp_slot + 2'd1;
      strobe_seen <= strobe_seen | evt_strobe;
    end
  end

  typedef struct packed {
    logic [4:0]  pre;
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [3:0]  fall;
    logic [15:0] e0;
    logic [15:0] e1;
    logic [15:0] e2;
    logic [15:0] e3;
  } vec_t;

  // All vectors clear the counter on every slot, so each stamp is interval-1.
  localparam vec_t VECS [7] = '{
    '{pre:5'd0, hi:8'd4, lo:8'd4, fall:4'b0000, e0:16'd7,  e1:16'd7,  e2:16'd7,  e3:16'd7},
    '{pre:5'd0, hi:8'd3, lo:8'd6, fall:4'b1111, e0:16'd8,  e1:16'd8,  e2:16'd8,  e3:16'd8},
    '{pre:5'd0, hi:8'd3, lo:8'd6, fall:4'b1010, e0:16'd5,  e1:16'd2,  e2:16'd5,  e3:16'd2},
    '{pre:5'd1, hi:8'd2, lo:8'd3, fall:4'b0000, e0:16'd9,  e1:16'd9,  e2:16'd9,  e3:16'd9},
    '{pre:5'd2, hi:8'd2, lo:8'd2, fall:4'b0000, e0:16'd15, e1:16'd15, e2:16'd15, e3:16'd15},
    '{pre:5'd2, hi:8'd3, lo:8'd3, fall:4'b1010, e0:16'd11, e1:16'd11, e2:16'd11, e3:16'd11},
    '{pre:5'd3, hi:8'd2, lo:8'd2, fall:4'b1111, e0:16'd23, e1:16'd23, e2:16'd23, e3:16'd23}
  };

  function automatic int divisor(input int n);
    return (n == 0) ? 1 : 2 * n;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sig_in = 1'b0; halt_req = 1'b0;
    cyc(3);
    rst_n = 1'b1;
  endtask

  task automatic square(input int hi, input int lo, input int count);
    for (int k = 0; k < count; k++) begin
      sig_in = 1'b1; cyc(hi);
      sig_in = 1'b0; cyc(lo);
    end
  endtask

  // Edges 20 cycles apart, halt held for 5 cycles in between.
  task automatic halt_probe(input logic [1:0] mode, input int exp_delta, input string req);
    cfg_halt_mode = mode; cfg_clr_after = 4'b0000; cfg_edge_fall = 4'b0000;
    cfg_prediv = 5'd0; cfg_load_en = 1'b1;
    do_reset();
    cyc(4);
    sig_in = 1'b1; cyc(10);
    sig_in = 1'b0; cyc(2);
    halt_req = 1'b1; cyc(5);
    halt_req = 1'b0; cyc(3);
    sig_in = 1'b1; cyc(10);
    sig_in = 1'b0; cyc(6);
    chk(req, stamp_1 - stamp_0, exp_delta);
  endtask

  task automatic run_tests();
    // R1 reset state
    cfg_load_en = 1'b1;
    rst_n = 1'b0; cyc(2);
    chk("R1 stamp_0 in reset", stamp_0, 0);
    chk("R1 strobe in reset", {28'd0, evt_strobe}, 0);
    rst_n = 1'b1; cyc(3);
    chk("R1 stamp_3 after reset", stamp_3, 0);

    // Table walk: R2 divide ratios, R3 polarity, R5 delta stamps
    for (int v = 0; v < 7; v++) begin
      cfg_prediv = VECS[v].pre; cfg_edge_fall = VECS[v].fall;
      cfg_clr_after = 4'b1111; cfg_load_en = 1'b1; cfg_halt_mode = 2'd2;
      do_reset();
      square(VECS[v].hi, VECS[v].lo, 6 * divisor(int'(VECS[v].pre)) + 2);
      cyc(6);
      chk($sformatf("R2/R3/R5 vec%0d slot0", v), stamp_0, {16'd0, VECS[v].e0});
      chk($sformatf("R2/R3/R5 vec%0d slot1", v), stamp_1, {16'd0, VECS[v].e1});
      chk($sformatf("R2/R3/R5 vec%0d slot2", v), stamp_2, {16'd0, VECS[v].e2});
      chk($sformatf("R2/R3/R5 vec%0d slot3", v), stamp_3, {16'd0, VECS[v].e3});
    end

    // R2 largest ratio: 31 gives /62, period 4 -> 248 cycles
    cfg_prediv = 5'd31; cfg_edge_fall = 4'b0000; cfg_clr_after = 4'b1111;
    do_reset();
    square(2, 2, 7 * 62);
    cyc(6);
    chk("R2 ratio 31 slot1", stamp_1, 247);
    chk("R2 ratio 31 slot2", stamp_2, 247);

    // R6 absolute mode and R5 clear on slot 1 only
    cfg_prediv = 5'd0; cfg_clr_after = 4'b0010;
    do_reset();
    square(6, 6, 4);
    cyc(6);
    chk("R6 absolute delta", stamp_1 - stamp_0, 12);
    chk("R5 after single clear", stamp_2, 11);
    chk("R6 absolute after clear", stamp_3, 23);

    // R7 loads disabled, rotation continues
    cfg_clr_after = 4'b0000; cfg_load_en = 1'b0;
    do_reset();
    square(5, 5, 2);
    cyc(5);
    chk("R7 stamp_0 unchanged", stamp_0, 0);
    chk("R7 stamp_1 unchanged", stamp_1, 0);
    chk("R7 strobes still seen", {28'd0, strobe_seen}, 32'h3);
    cfg_load_en = 1'b1;
    square(5, 5, 1);
    cyc(5);
    chk("R7 next load goes to slot 2", {31'd0, stamp_2 != 0}, 1);
    chk("R7 slot 0 still unloaded", stamp_0, 0);

    // R8 / R9 / R10 halt modes
    halt_probe(2'd0, 15, "R8 halt now");
    halt_probe(2'd2, 20, "R10 mode 2");
    halt_probe(2'd3, 20, "R10 mode 3");
    halt_probe(2'd1, 20, "R9 runs while nonzero");
    cfg_clr_after = 4'b1111; halt_req = 1'b1;
    square(5, 5, 3);
    cyc(6);
    chk("R9 held at zero slot3", stamp_3, 0);
    chk("R9 held at zero slot0", stamp_0, 0);
    halt_req = 1'b0;

    // R11 latency
    cfg_halt_mode = 2'd2; cfg_clr_after = 4'b0000; cfg_prediv = 5'd0;
    do_reset();
    cyc(2);
    sig_in = 1'b1;
    cyc(2);
    chk("R11 bypass no strobe at 2", {28'd0, evt_strobe}, 0);
    cyc(1);
    chk("R11 bypass strobe at 3", {28'd0, evt_strobe}, 1);
    cyc(1);
    chk("R4 strobe lasts one cycle", {28'd0, evt_strobe}, 0);
    cfg_prediv = 5'd1;
    do_reset();
    cyc(2);
    sig_in = 1'b1;
    cyc(3);
    chk("R11 divided no strobe at 3", {28'd0, evt_strobe}, 0);
    cyc(1);
    chk("R11 divided strobe at 4", {28'd0, evt_strobe}, 1);

    // R12 ratio change restarts the divider count
    cfg_prediv = 5'd3;
    do_reset();
    square(3, 3, 2);
    cyc(4);
    cfg_prediv = 5'd2;
    cyc(3);
    square(3, 3, 1);
    cyc(6);
    chk("R12 no toggle after one fresh edge", {28'd0, strobe_seen}, 0);
    square(3, 3, 1);
    cyc(6);
    chk("R12 toggle after two fresh edges", {28'd0, strobe_seen}, 1);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors",
             n_checks + mon_checks, n_err + mon_err);
    $finish;
  end
endmodule